// File: doc/BRIEF.md
# Per-Pipe Buffer-Ready Interrupt Status

This block holds one buffer-ready status bit for every endpoint pipe of a USB host/function controller, and it combines those bits into a single interrupt request. The packet engine and the FIFO memory sit outside the block. They report per-pipe readiness, packet arrivals (with short and zero-length markers), read completion and a transaction count. From these the block derives each pipe's status according to a status mode. The CPU sees the status as a register and clears individual bits by writing 0 to their positions.

There are three status modes. When the global mirror bit is 1, the status follows FIFO readiness live. When it is 0, each pipe's end-of-transfer bit chooses between two modes. With that bit at 1, the pipe flags only the completion of a whole receive transfer. With it at 0, the pipe latches rising edges of readiness. Zero-length packets and the control pipe need special treatment. A per-pipe auto-clear strobe discards transfer progress, so that a pipe's mode can be changed safely.

Top module: `bufrdy_irq_status`

## Requirements
- R1: With `mirror_mode_i`=1, a non-control transmit pipe (`dir_tx_i` bit = 1) shows its status equal to its `fifo_wr_rdy_i` bit, one clock later.
- R2: With `mirror_mode_i`=1, a transmit pipe with `ctrl_pipe_i`=1 keeps its status at 0, even while it is writable.
- R3: With `mirror_mode_i`=1, a receive pipe (`dir_tx_i` bit = 0) shows its status equal to its `fifo_rd_rdy_i` bit, one clock later, so the bit drops once the data is read out.
- R4: With `mirror_mode_i`=1, a zero-length packet that arrives (`pkt_rx_i` and `pkt_zlp_i`) while `fifo_rd_rdy_i` is 0 holds the status at 1 until a `buf_clr_i` pulse on that pipe.
- R5: With `mirror_mode_i`=1, status register writes (`sts_wr_i`, where bit i of `sts_wdata_i` belongs to pipe i) leave the status unchanged.
- R6: `cfg_err_o` bit i is 1 one clock after a cycle in which `mirror_mode_i` and `eot_mode_i` bit i are both 1, and 0 otherwise.
- R7: In end-of-transfer mode (`mirror_mode_i`=0, `eot_mode_i` bit = 1), a receive pipe sets its status in the cycle after a `rd_done_i` pulse, once a short or zero-length packet has arrived (in that cycle or earlier). It does not set on the packet alone.
- R8: In end-of-transfer mode with `trn_en_i` set, the arrival of the `trn_cnt_i` -th packet (field i is `trn_cnt_i[i*TRN_W +: TRN_W]`, where 0 disables the count) also counts as the end of the transfer, again taking effect at the next `rd_done_i`.
- R9: In end-of-transfer mode, a zero-length packet that arrives while `fifo_rd_rdy_i` is 0 sets the status at once. All further packets on that pipe are then ignored until a `buf_clr_i` pulse.
- R10: In end-of-transfer mode, a transmit pipe never sets its status. On any pipe that is not in mirror mode, writing 0 to bit i clears status bit i.
- R11: An `auto_clr_i` pulse clears that pipe's status bit on the next clock and discards its transfer progress.
- R12: In event mode (both mode bits 0), a rising edge of the pipe's readiness (`fifo_wr_rdy_i` for transmit, `fifo_rd_rdy_i` for receive) sets the status, which stays set until a write of 0. A set and a clear in the same cycle leave the bit at 1.
- R13: `irq_o` equals the OR over all pipes of status AND `irq_en_i`, one clock after the status.
- R14: After reset, all status bits, `irq_o` and `cfg_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mirror_mode_i | input | 1 | Global mode: 1 = status mirrors readiness |
| eot_mode_i | input | NUM_PIPES | Per-pipe end-of-transfer mode |
| dir_tx_i | input | NUM_PIPES | 1 = transmit pipe, 0 = receive pipe |
| ctrl_pipe_i | input | NUM_PIPES | Marks the control pipe |
| fifo_wr_rdy_i | input | NUM_PIPES | CPU may write the pipe's FIFO port |
| fifo_rd_rdy_i | input | NUM_PIPES | CPU may read the pipe's FIFO port |
| pkt_rx_i | input | NUM_PIPES | Packet received strobe |
| pkt_short_i | input | NUM_PIPES | Received packet is short |
| pkt_zlp_i | input | NUM_PIPES | Received packet has zero length |
| rd_done_i | input | NUM_PIPES | Buffer fully read out strobe |
| trn_en_i | input | NUM_PIPES | Transaction counter enabled |
| trn_cnt_i | input | NUM_PIPES*TRN_W | Per-pipe packet count per transfer |
| buf_clr_i | input | NUM_PIPES | Buffer-clear strobe |
| auto_clr_i | input | NUM_PIPES | FIFO auto-clear strobe |
| irq_en_i | input | NUM_PIPES | Per-pipe interrupt enable |
| sts_wr_i | input | 1 | CPU write to the status register |
| sts_wdata_i | input | NUM_PIPES | Write data: 0 clears the bit |
| sts_o | output | NUM_PIPES | Status bits |
| irq_o | output | 1 | Interrupt request |
| cfg_err_o | output | NUM_PIPES | Mirror and end-of-transfer both set |

## Verification
A wrong internal state shows up at `sts_o` one clock after the stimulus that should have been reflected, and at `irq_o` one clock after that. Transfer progress is hidden: a lost packet count or a lost terminator only becomes visible at the next `rd_done_i`, where the status stays 0 instead of rising. A stuck hold or wait flag becomes visible either as a status that fails to drop after `buf_clr_i`, or as a later transfer that never completes. For this reason the bench always follows each hidden-state stimulus with the strobe that exposes it.

// File: rtl/bri_pkg.sv
package bri_pkg;
  typedef enum logic [1:0] {
    MODE_EVENT  = 2'd0,
    MODE_EOT    = 2'd1,
    MODE_MIRROR = 2'd2
  } sts_mode_e;

  // global mirror dominates; a pipe with both bits set still mirrors
  function automatic sts_mode_e pick_mode(input logic mirror, input logic eot);
    if (mirror)   return MODE_MIRROR;
    else if (eot) return MODE_EOT;
    else          return MODE_EVENT;
  endfunction
endpackage

// File: rtl/bri_trn_track.sv
module bri_trn_track #(
  parameter int TRN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             pkt_rx_i,
  input  logic             short_i,
  input  logic             zlp_i,
  input  logic             fifo_empty_i,
  input  logic             rd_done_i,
  input  logic             trn_en_i,
  input  logic [TRN_W-1:0] trn_cnt_i,
  input  logic             buf_clr_i,
  input  logic             restart_i,
  output logic             done_o
);
  logic [TRN_W-1:0] cnt_q, cnt_inc;
  logic             term_q, wait_q;
  logic             accept, zlp_empty, cnt_hit, term_now, fin;

  always_comb begin
    accept    = active_i & pkt_rx_i & ~wait_q;
    zlp_empty = accept & zlp_i & fifo_empty_i;
    cnt_inc   = cnt_q + 1'b1;
    cnt_hit   = trn_en_i & (trn_cnt_i != '0) & (cnt_inc == trn_cnt_i);
    term_now  = accept & (short_i | zlp_i | cnt_hit);
    fin       = active_i & ~wait_q & rd_done_i & (term_q | term_now);
    done_o    = zlp_empty | fin;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
      wait_q <= 1'b0;
    end else if (!active_i || restart_i || buf_clr_i) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
      wait_q <= 1'b0;
    end else if (zlp_empty) begin
      // transfer ends at hand-over; hold off until buffer clear
      cnt_q  <= '0;
      term_q <= 1'b0;
      wait_q <= 1'b1;
    end else if (fin) begin
      cnt_q  <= '0;
      term_q <= 1'b0;
    end else begin
      if (accept)   cnt_q  <= cnt_inc;
      if (term_now) term_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bri_pipe_ctx.sv
module bri_pipe_ctx
  import bri_pkg::*;
#(
  parameter int TRN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mirror_i,
  input  logic             eot_i,
  input  logic             dir_tx_i,
  input  logic             ctrl_i,
  input  logic             wr_rdy_i,
  input  logic             rd_rdy_i,
  input  logic             pkt_rx_i,
  input  logic             short_i,
  input  logic             zlp_i,
  input  logic             rd_done_i,
  input  logic             trn_en_i,
  input  logic [TRN_W-1:0] trn_cnt_i,
  input  logic             buf_clr_i,
  input  logic             auto_clr_i,
  input  logic             wclr_i,
  output logic             sts_o,
  output logic             cfg_err_o
);
  sts_mode_e mode;
  logic      rdy_now, rdy_q;
  logic      zlp_hold_d, zlp_hold_q;
  logic      sts_d, sts_q, cfg_q;
  logic      eot_done;

  assign mode    = pick_mode(mirror_i, eot_i);
  assign rdy_now = dir_tx_i ? wr_rdy_i : rd_rdy_i;

  bri_trn_track #(.TRN_W(TRN_W)) u_trk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (mode == MODE_EOT),
    .pkt_rx_i    (pkt_rx_i),
    .short_i     (short_i),
    .zlp_i       (zlp_i),
    .fifo_empty_i(~rd_rdy_i),
    .rd_done_i   (rd_done_i),
    .trn_en_i    (trn_en_i),
    .trn_cnt_i   (trn_cnt_i),
    .buf_clr_i   (buf_clr_i),
    .restart_i   (auto_clr_i),
    .done_o      (eot_done)
  );

  always_comb begin
    zlp_hold_d = (mode == MODE_MIRROR) & ~auto_clr_i & ~dir_tx_i &
                 ((pkt_rx_i & zlp_i & ~rd_rdy_i) | (zlp_hold_q & ~buf_clr_i));
    sts_d = sts_q;
    if (auto_clr_i) begin
      sts_d = 1'b0;
    end else begin
      unique case (mode)
        MODE_MIRROR: sts_d = dir_tx_i ? (wr_rdy_i & ~ctrl_i) : (rd_rdy_i | zlp_hold_d);
        MODE_EOT: begin
          if (eot_done && !dir_tx_i) sts_d = 1'b1;
          else if (wclr_i)           sts_d = 1'b0;
        end
        default: begin
          if (rdy_now && !rdy_q) sts_d = 1'b1;
          else if (wclr_i)       sts_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q      <= 1'b0;
      zlp_hold_q <= 1'b0;
      sts_q      <= 1'b0;
      cfg_q      <= 1'b0;
    end else begin
      rdy_q      <= rdy_now;
      zlp_hold_q <= zlp_hold_d;
      sts_q      <= sts_d;
      cfg_q      <= mirror_i & eot_i;
    end
  end

  assign sts_o     = sts_q;
  assign cfg_err_o = cfg_q;
endmodule

// File: rtl/bri_irq_merge.sv
module bri_irq_merge #(
  parameter int NUM_PIPES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PIPES-1:0] sts_i,
  input  logic [NUM_PIPES-1:0] en_i,
  output logic                 irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sts_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/bufrdy_irq_status.sv
module bufrdy_irq_status #(
  parameter int NUM_PIPES = 8,
  parameter int TRN_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mirror_mode_i,
  input  logic [NUM_PIPES-1:0]       eot_mode_i,
  input  logic [NUM_PIPES-1:0]       dir_tx_i,
  input  logic [NUM_PIPES-1:0]       ctrl_pipe_i,
  input  logic [NUM_PIPES-1:0]       fifo_wr_rdy_i,
  input  logic [NUM_PIPES-1:0]       fifo_rd_rdy_i,
  input  logic [NUM_PIPES-1:0]       pkt_rx_i,
  input  logic [NUM_PIPES-1:0]       pkt_short_i,
  input  logic [NUM_PIPES-1:0]       pkt_zlp_i,
  input  logic [NUM_PIPES-1:0]       rd_done_i,
  input  logic [NUM_PIPES-1:0]       trn_en_i,
  input  logic [NUM_PIPES*TRN_W-1:0] trn_cnt_i,
  input  logic [NUM_PIPES-1:0]       buf_clr_i,
  input  logic [NUM_PIPES-1:0]       auto_clr_i,
  input  logic [NUM_PIPES-1:0]       irq_en_i,
  input  logic                       sts_wr_i,
  input  logic [NUM_PIPES-1:0]       sts_wdata_i,
  output logic [NUM_PIPES-1:0]       sts_o,
  output logic                       irq_o,
  output logic [NUM_PIPES-1:0]       cfg_err_o
);
  logic [NUM_PIPES-1:0] wclr;
  logic [NUM_PIPES-1:0] sts;

  assign wclr = {NUM_PIPES{sts_wr_i}} & ~sts_wdata_i;

  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_pipe
    bri_pipe_ctx #(.TRN_W(TRN_W)) u_pipe (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mirror_i  (mirror_mode_i),
      .eot_i     (eot_mode_i[i]),
      .dir_tx_i  (dir_tx_i[i]),
      .ctrl_i    (ctrl_pipe_i[i]),
      .wr_rdy_i  (fifo_wr_rdy_i[i]),
      .rd_rdy_i  (fifo_rd_rdy_i[i]),
      .pkt_rx_i  (pkt_rx_i[i]),
      .short_i   (pkt_short_i[i]),
      .zlp_i     (pkt_zlp_i[i]),
      .rd_done_i (rd_done_i[i]),
      .trn_en_i  (trn_en_i[i]),
      .trn_cnt_i (trn_cnt_i[i*TRN_W +: TRN_W]),
      .buf_clr_i (buf_clr_i[i]),
      .auto_clr_i(auto_clr_i[i]),
      .wclr_i    (wclr[i]),
      .sts_o     (sts[i]),
      .cfg_err_o (cfg_err_o[i])
    );
  end

  bri_irq_merge #(.NUM_PIPES(NUM_PIPES)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sts_i (sts),
    .en_i  (irq_en_i),
    .irq_o (irq_o)
  );

  assign sts_o = sts;
endmodule

// File: rtl/bri_sts_chk.sv
module bri_sts_chk #(
  parameter int NUM_PIPES = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 mirror_mode_i,
  input logic [NUM_PIPES-1:0] eot_mode_i,
  input logic [NUM_PIPES-1:0] dir_tx_i,
  input logic [NUM_PIPES-1:0] ctrl_pipe_i,
  input logic [NUM_PIPES-1:0] fifo_wr_rdy_i,
  input logic [NUM_PIPES-1:0] fifo_rd_rdy_i,
  input logic [NUM_PIPES-1:0] auto_clr_i,
  input logic [NUM_PIPES-1:0] irq_en_i,
  input logic [NUM_PIPES-1:0] sts_o,
  input logic                 irq_o,
  input logic [NUM_PIPES-1:0] cfg_err_o
);
  for (genvar i = 0; i < NUM_PIPES; i++) begin : g_chk
    a_r1_mirror_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mirror_mode_i && dir_tx_i[i] && !ctrl_pipe_i[i] && !auto_clr_i[i])
        |=> (sts_o[i] == $past(fifo_wr_rdy_i[i])));

    a_r2_ctrl_tx_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mirror_mode_i && dir_tx_i[i] && ctrl_pipe_i[i]) |=> !sts_o[i]);

    a_r3_mirror_rx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mirror_mode_i && !dir_tx_i[i] && fifo_rd_rdy_i[i] && !auto_clr_i[i]) |=> sts_o[i]);

    a_r6_cfg_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (cfg_err_o[i] == $past(mirror_mode_i && eot_mode_i[i])));

    a_r10_eot_tx_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mirror_mode_i && eot_mode_i[i] && dir_tx_i[i] && !sts_o[i]) |=> !sts_o[i]);

    a_r11_auto_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      auto_clr_i[i] |=> !sts_o[i]);
  end

  a_r13_irq_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |($past(sts_o) & $past(irq_en_i))));
endmodule

bind bufrdy_irq_status bri_sts_chk #(.NUM_PIPES(NUM_PIPES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mirror_mode_i(mirror_mode_i),
  .eot_mode_i   (eot_mode_i),
  .dir_tx_i     (dir_tx_i),
  .ctrl_pipe_i  (ctrl_pipe_i),
  .fifo_wr_rdy_i(fifo_wr_rdy_i),
  .fifo_rd_rdy_i(fifo_rd_rdy_i),
  .auto_clr_i   (auto_clr_i),
  .irq_en_i     (irq_en_i),
  .sts_o        (sts_o),
  .irq_o        (irq_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/bufrdy_irq_status_tb.sv
module bufrdy_irq_status_tb;
  localparam int N = 8;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mirror_mode_i = 1'b0;
  logic [N-1:0] eot_mode_i = '0, dir_tx_i = '0, ctrl_pipe_i = '0;
  logic [N-1:0] fifo_wr_rdy_i = '0, fifo_rd_rdy_i = '0;
  logic [N-1:0] pkt_rx_i = '0, pkt_short_i = '0, pkt_zlp_i = '0, rd_done_i = '0;
  logic [N-1:0] trn_en_i = '0, buf_clr_i = '0, auto_clr_i = '0, irq_en_i = '0;
  logic [N*W-1:0] trn_cnt_i = '0;
  logic         sts_wr_i = 1'b0;
  logic [N-1:0] sts_wdata_i = '0;
  logic [N-1:0] sts_o, cfg_err_o;
  logic         irq_o;

  always #2.5 clk_i = ~clk_i;

  bufrdy_irq_status #(.NUM_PIPES(N), .TRN_W(W)) u_dut (.*);

  typedef struct {
    string req;
    int    kind;  // 0 status bit, 1 irq, 2 cfg error bit
    int    idx;
    logic  exp;
    int    due;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic push(input string req, input int kind, input int idx,
                      input logic exp, input int lat);
    item_t it;
    it.req = req; it.kind = kind; it.idx = idx; it.exp = exp; it.due = cyc + lat;
    sbq.push_back(it);
  endtask

  task automatic exp_sts(input string req, input int idx, input logic v);
    push(req, 0, idx, v, 1);
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // monitor: compares due items away from the active edge
  always @(negedge clk_i) begin
    for (int k = sbq.size() - 1; k >= 0; k--) begin
      if (sbq[k].due <= cyc) begin
        logic act;
        case (sbq[k].kind)
          0:       act = sts_o[sbq[k].idx];
          1:       act = irq_o;
          default: act = cfg_err_o[sbq[k].idx];
        endcase
        n_chk++;
        if (act !== sbq[k].exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d pipe=%0d actual=%b expected=%b cycle=%0d",
                   sbq[k].req, sbq[k].kind, sbq[k].idx, act, sbq[k].exp, cyc);
        end
        sbq.delete(k);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R14 reset state
    for (int p = 0; p < N; p++) begin
      exp_sts("R14", p, 1'b0);
      push("R14", 2, p, 1'b0, 1);
    end
    push("R14", 1, 0, 1'b0, 1);
    tick();

    // mirror mode: rx, tx, control tx
    mirror_mode_i = 1'b1; irq_en_i = '1;
    fifo_rd_rdy_i[0] = 1'b1;
    dir_tx_i[1] = 1'b1; fifo_wr_rdy_i[1] = 1'b1;
    dir_tx_i[2] = 1'b1; ctrl_pipe_i[2] = 1'b1; fifo_wr_rdy_i[2] = 1'b1;
    exp_sts("R3", 0, 1'b1); exp_sts("R1", 1, 1'b1); exp_sts("R2", 2, 1'b0);
    push("R13", 1, 0, 1'b1, 2);
    tick();
    sts_wr_i = 1'b1; sts_wdata_i = '0;
    exp_sts("R5", 0, 1'b1); exp_sts("R5", 1, 1'b1);
    tick();
    sts_wr_i = 1'b0;
    fifo_rd_rdy_i[0] = 1'b0; fifo_wr_rdy_i[1] = 1'b0;
    exp_sts("R3", 0, 1'b0); exp_sts("R1", 1, 1'b0); exp_sts("R2", 2, 1'b0);
    push("R13", 1, 0, 1'b0, 2);
    tick(); tick();

    // mirror mode zero-length packet into empty FIFO
    pkt_rx_i[3] = 1'b1; pkt_zlp_i[3] = 1'b1;
    exp_sts("R4", 3, 1'b1);
    tick();
    pkt_rx_i = '0; pkt_zlp_i = '0;
    exp_sts("R4", 3, 1'b1);
    tick();
    exp_sts("R4", 3, 1'b1);
    tick();
    buf_clr_i[3] = 1'b1;
    exp_sts("R4", 3, 1'b0);
    tick();
    buf_clr_i = '0;

    // configuration error
    eot_mode_i[4] = 1'b1;
    push("R6", 2, 4, 1'b1, 1);
    tick();
    eot_mode_i[4] = 1'b0;
    push("R6", 2, 4, 1'b0, 1);
    tick();

    // interrupt enable masking
    irq_en_i = ~8'h20; fifo_rd_rdy_i[5] = 1'b1;
    exp_sts("R3", 5, 1'b1);
    push("R13", 1, 0, 1'b0, 2);
    tick(); tick();
    fifo_rd_rdy_i[5] = 1'b0;
    tick(); tick();
    irq_en_i = '1;
    tick();

    // end-of-transfer: short packet then read done
    mirror_mode_i = 1'b0; eot_mode_i[0] = 1'b1;
    tick();
    fifo_rd_rdy_i[0] = 1'b1; pkt_rx_i[0] = 1'b1; pkt_short_i[0] = 1'b1;
    exp_sts("R7", 0, 1'b0);
    tick();
    pkt_rx_i = '0; pkt_short_i = '0;
    exp_sts("R7", 0, 1'b0);
    tick();
    rd_done_i[0] = 1'b1; fifo_rd_rdy_i[0] = 1'b0;
    exp_sts("R7", 0, 1'b1);
    push("R13", 1, 0, 1'b1, 2);
    tick();
    rd_done_i = '0;
    tick();
    sts_wr_i = 1'b1; sts_wdata_i = ~8'h01;
    exp_sts("R10", 0, 1'b0);
    tick();
    sts_wr_i = 1'b0;

    // end-of-transfer: transaction counter of 3
    dir_tx_i[1] = 1'b0; eot_mode_i[1] = 1'b1; trn_en_i[1] = 1'b1;
    trn_cnt_i[1*W +: W] = 8'd3;
    tick();
    for (int n = 0; n < 3; n++) begin
      pkt_rx_i[1] = 1'b1; fifo_rd_rdy_i[1] = 1'b1;
      tick();
      pkt_rx_i[1] = 1'b0; rd_done_i[1] = 1'b1; fifo_rd_rdy_i[1] = 1'b0;
      exp_sts("R8", 1, (n == 2) ? 1'b1 : 1'b0);
      tick();
      rd_done_i[1] = 1'b0;
    end
    sts_wr_i = 1'b1; sts_wdata_i = ~8'h02;
    exp_sts("R10", 1, 1'b0);
    tick();
    sts_wr_i = 1'b0;

    // end-of-transfer: zero-length packet into empty FIFO, then blocked
    pkt_rx_i[0] = 1'b1; pkt_zlp_i[0] = 1'b1;
    exp_sts("R9", 0, 1'b1);
    tick();
    pkt_rx_i = '0; pkt_zlp_i = '0;
    sts_wr_i = 1'b1; sts_wdata_i = ~8'h01;
    exp_sts("R10", 0, 1'b0);
    tick();
    sts_wr_i = 1'b0;
    pkt_rx_i[0] = 1'b1; pkt_short_i[0] = 1'b1; rd_done_i[0] = 1'b1;
    exp_sts("R9", 0, 1'b0);
    tick();
    pkt_rx_i = '0; pkt_short_i = '0; rd_done_i = '0;
    buf_clr_i[0] = 1'b1;
    tick();
    buf_clr_i = '0;
    pkt_rx_i[0] = 1'b1; pkt_short_i[0] = 1'b1; rd_done_i[0] = 1'b1;
    exp_sts("R9", 0, 1'b1);
    tick();
    pkt_rx_i = '0; pkt_short_i = '0; rd_done_i = '0;
    sts_wr_i = 1'b1; sts_wdata_i = ~8'h01;
    exp_sts("R10", 0, 1'b0);
    tick();
    sts_wr_i = 1'b0;

    // end-of-transfer: transmit pipe stays silent
    ctrl_pipe_i[2] = 1'b0; eot_mode_i[2] = 1'b1;
    tick();
    pkt_rx_i[2] = 1'b1; pkt_short_i[2] = 1'b1; rd_done_i[2] = 1'b1;
    exp_sts("R10", 2, 1'b0);
    tick();
    pkt_rx_i = '0; pkt_short_i = '0; rd_done_i = '0;

    // auto-clear discards progress and status
    pkt_rx_i[0] = 1'b1; pkt_short_i[0] = 1'b1; fifo_rd_rdy_i[0] = 1'b1;
    tick();
    pkt_rx_i = '0; pkt_short_i = '0;
    auto_clr_i[0] = 1'b1;
    exp_sts("R11", 0, 1'b0);
    tick();
    auto_clr_i = '0;
    rd_done_i[0] = 1'b1; fifo_rd_rdy_i[0] = 1'b0;
    exp_sts("R11", 0, 1'b0);
    tick();
    rd_done_i = '0;
    pkt_rx_i[0] = 1'b1; pkt_short_i[0] = 1'b1; rd_done_i[0] = 1'b1;
    exp_sts("R7", 0, 1'b1);
    tick();
    pkt_rx_i = '0; pkt_short_i = '0; rd_done_i = '0;
    auto_clr_i[0] = 1'b1;
    exp_sts("R11", 0, 1'b0);
    tick();
    auto_clr_i = '0;

    // event mode
    fifo_rd_rdy_i[6] = 1'b1;
    exp_sts("R12", 6, 1'b1);
    tick();
    fifo_rd_rdy_i[6] = 1'b0;
    exp_sts("R12", 6, 1'b1);
    tick();
    sts_wr_i = 1'b1; sts_wdata_i = ~8'h40;
    exp_sts("R12", 6, 1'b0);
    tick();
    fifo_rd_rdy_i[6] = 1'b1;
    exp_sts("R12", 6, 1'b1);
    tick();
    exp_sts("R12", 6, 1'b0);
    tick();
    sts_wr_i = 1'b0;
    dir_tx_i[7] = 1'b1; fifo_wr_rdy_i[7] = 1'b1;
    exp_sts("R12", 7, 1'b1);
    tick();

    repeat (4) tick();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule